// File: doc/BRIEF.md
# SPI Register-Access Target

This block is the target end of a framed SPI link into the register space of a security coprocessor. The host pulls chip select low and sends a four-byte header. The first byte is a command. Its top bit selects read or write, and its low six bits give the transfer length minus one. The next three bytes are a 24-bit register address, sent most significant byte first. The address is decoded into a locality number and a 12-bit register offset. Each payload byte then becomes one strobe on a simple register-side port. A read strobe fetches a byte that is shifted back on MISO. A write strobe hands over the byte just received.

The SPI pins are sampled by the system clock through a synchronizer, so the link runs in SPI mode 0. MOSI is taken on the rising SCLK edge, MISO changes after the falling edge, and every byte travels MSB first. The per-locality data FIFO register sits at offset 0x024. Repeated accesses to it keep the same offset, so each data byte pops or pushes one FIFO entry. Accesses to any other offset advance the offset by one per byte. The bus is shared with other devices, so MISO is enabled only while this target is selected.

Top module: `spi_reg_target`

## Requirements
- R1: Mode 0, MSB first. MOSI is taken on SCLK rising edges and MISO is updated after falling edges. `miso_oe_o` is high only while chip select is low, and it falls within a few clocks of chip select rising.
- R2: Command bit 7 selects the direction, 1 for read and 0 for write. Command bit 6 has no effect on the transfer.
- R3: Command bits 5:0 hold N-1 for an N-byte transfer. Exactly N register strobes are issued when a decoded transfer runs for at least N data bytes.
- R4: The header is the command byte followed by the 24-bit address, MSB first. Read data starts with the 33rd SCLK cycle, so a one-byte read completes in 40 SCLK cycles.
- R5: MISO is driven low throughout the 32 header bits.
- R6: An address is decoded when bits 23:16 equal 0xD4. `reg_loc_o` then carries address bits 15:12 and `reg_off_o` carries bits 11:0.
- R7: For an undecoded address, read bytes return 0xFF and no register strobe is issued, for reads or writes.
- R8: At offset 0x024 the offset is held across bytes. Every other offset increments by one per byte. A read strobe answered with `reg_rvalid_i` low returns 0xFF.
- R9: Data bytes clocked beyond the command length return 0xFF on reads and are ignored on writes, with no strobe.
- R10: Raising chip select mid-transaction discards the partial header or byte, issues no strobe for it, and the next transaction decodes from a fresh header.
- R11: After reset, `miso_o`, `miso_oe_o` and `reg_stb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples SCLK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Host-to-target serial data |
| miso_o | output | 1 | Target-to-host serial data |
| miso_oe_o | output | 1 | MISO output enable for the shared bus |
| reg_stb_o | output | 1 | One-cycle register access strobe |
| reg_we_o | output | 1 | Strobe is a write when high |
| reg_loc_o | output | 4 | Locality of the access |
| reg_off_o | output | 12 | Register offset of the access |
| reg_wdata_o | output | 8 | Write byte |
| reg_rdata_i | input | 8 | Read byte, valid during the strobe cycle |
| reg_rvalid_i | input | 1 | Read byte available; low returns 0xFF |

## Verification
The synchronizer sets the latency. A SCLK edge reaches the logic two clocks after the pin changes. The register strobe follows one clock after the rising edge that completes a byte, and the read byte is captured in the clock after the strobe. That byte appears on MISO about three clocks after the next falling edge. The bench holds each SCLK level for eight clocks. It sets MOSI right after a falling edge and samples MISO just before raising SCLK, so every result has settled by the time it is read. Strobe counts and write logs are taken at the register port once chip select has been high for eight clocks.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam logic [7:0]  DEC_PAGE = 8'hD4;
  localparam logic [11:0] FIFO_OFF = 12'h024;
  localparam logic [7:0]  IDLE_BYTE = 8'hFF;

  typedef struct packed {
    logic       rd;
    logic       rsvd;
    logic [5:0] len_m1;
  } cmd_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sel_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sclk_i;
  end

  assign rise_o = sel_i &  sclk_i & ~prev_q;
  assign fall_o = sel_i & ~sclk_i &  prev_q;
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       fall_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       miso_o
);
  logic [7:0] tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tx_q <= '0;
    else if (!sel_i) tx_q <= '0;
    else if (fall_i) tx_q <= load_i ? data_i : {tx_q[6:0], 1'b0};
  end

  assign miso_o = tx_q[7];
endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sclk_i,
  input  logic        cs_ni,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic        miso_oe_o,
  output logic        reg_stb_o,
  output logic        reg_we_o,
  output logic [3:0]  reg_loc_o,
  output logic [11:0] reg_off_o,
  output logic [7:0]  reg_wdata_o,
  input  logic [7:0]  reg_rdata_i,
  input  logic        reg_rvalid_i
);
  logic sclk_s, cs_n_s, mosi_s, sel, rise, fall;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni,
    .d_i({sclk_i, cs_ni, mosi_i}),
    .q_o({sclk_s, cs_n_s, mosi_s})
  );

  assign sel = ~cs_n_s;

  spi_edge_det u_edge (
    .clk_i, .rst_ni, .sclk_i(sclk_s), .sel_i(sel), .rise_o(rise), .fall_o(fall)
  );

  logic [2:0]       bit_q;
  logic [1:0]       hdr_q;
  logic             data_q;
  logic [6:0]       sh_q;
  logic [7:0]       sh_nxt;
  cmd_t             cmd_q;
  logic [7:0]       ahi_q, amid_q;
  logic [CNT_W-1:0] dcnt_q, len_w;
  logic             dec_q;
  logic [3:0]       cur_loc_q;
  logic [11:0]      cur_off_q;
  logic [7:0]       nxt_q;
  logic             byte_done, hdr_end, iss, iss_we, eff_dec, tx_load;
  logic [3:0]       eff_loc;
  logic [11:0]      eff_off;

  assign sh_nxt    = {sh_q, mosi_s};
  assign byte_done = rise && (bit_q == 3'd7);
  assign hdr_end   = byte_done && !data_q && (hdr_q == 2'd3);
  assign len_w     = CNT_W'(cmd_q.len_m1);
  assign eff_dec   = hdr_end ? (ahi_q == DEC_PAGE) : dec_q;
  assign eff_loc   = hdr_end ? amid_q[7:4] : cur_loc_q;
  assign eff_off   = hdr_end ? {amid_q[3:0], sh_nxt} : cur_off_q;

  // first read fetch at header end; later fetches only while bytes remain
  always_comb begin
    iss    = 1'b0;
    iss_we = 1'b0;
    if (hdr_end) begin
      iss = cmd_q.rd && eff_dec;
    end else if (byte_done && data_q) begin
      if (cmd_q.rd) begin
        iss = eff_dec && (dcnt_q < len_w);
      end else begin
        iss    = eff_dec && (dcnt_q <= len_w);
        iss_we = iss;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      hdr_q  <= '0;
      data_q <= 1'b0;
      sh_q   <= '0;
      cmd_q  <= '0;
      ahi_q  <= '0;
      amid_q <= '0;
      dcnt_q <= '0;
    end else if (!sel) begin
      bit_q  <= '0;
      hdr_q  <= '0;
      data_q <= 1'b0;
      sh_q   <= '0;
      dcnt_q <= '0;
    end else if (rise) begin
      bit_q <= bit_q + 3'd1;
      sh_q  <= sh_nxt[6:0];
      if (bit_q == 3'd7) begin
        if (data_q) begin
          if (dcnt_q != '1) dcnt_q <= dcnt_q + CNT_W'(1);
        end else begin
          case (hdr_q)
            2'd0:    cmd_q  <= cmd_t'(sh_nxt);
            2'd1:    ahi_q  <= sh_nxt;
            2'd2:    amid_q <= sh_nxt;
            default: data_q <= 1'b1;
          endcase
          hdr_q <= hdr_q + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_stb_o   <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_loc_o   <= '0;
      reg_off_o   <= '0;
      reg_wdata_o <= '0;
      dec_q       <= 1'b0;
      cur_loc_q   <= '0;
      cur_off_q   <= '0;
      nxt_q       <= IDLE_BYTE;
    end else begin
      reg_stb_o <= iss;
      reg_we_o  <= iss_we;
      if (hdr_end) dec_q <= eff_dec;
      if (iss) begin
        reg_loc_o   <= eff_loc;
        reg_off_o   <= eff_off;
        reg_wdata_o <= sh_nxt;
        cur_loc_q   <= eff_loc;
        cur_off_q   <= (eff_off == FIFO_OFF) ? eff_off : eff_off + 12'd1;
      end else if (hdr_end) begin
        cur_loc_q <= eff_loc;
        cur_off_q <= eff_off;
      end
      if (reg_stb_o && !reg_we_o)
        nxt_q <= reg_rvalid_i ? reg_rdata_i : IDLE_BYTE;
      else if ((hdr_end || (byte_done && data_q)) && !(iss && !iss_we))
        nxt_q <= IDLE_BYTE;
    end
  end

  assign tx_load = data_q && (bit_q == 3'd0);

  spi_tx_shift u_tx (
    .clk_i, .rst_ni, .sel_i(sel), .fall_i(fall), .load_i(tx_load),
    .data_i(nxt_q), .miso_o
  );

  assign miso_oe_o = sel;

  // R5
  hdr_miso_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !data_q) |-> !miso_o);

  // R10
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |=> (bit_q == 3'd0 && hdr_q == 2'd0 && !data_q));

  // R7
  stb_decoded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_stb_o |-> dec_q);

  // R2
  wr_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_stb_o && reg_we_o) |-> !cmd_q.rd);

  // R8
  fifo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_stb_o && reg_off_o == FIFO_OFF) |-> (cur_off_q == FIFO_OFF));

  // R3
  stb_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_stb_o |=> !reg_stb_o);
endmodule

// File: tb/tb_spi_reg_target.sv
module tb_spi_reg_target;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, oe, stb, we, rvalid;
  logic [3:0] loc;
  logic [11:0] off;
  logic [7:0] wdata, rdata;

  always #2 clk = ~clk;

  spi_reg_target dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(oe), .reg_stb_o(stb), .reg_we_o(we),
    .reg_loc_o(loc), .reg_off_o(off), .reg_wdata_o(wdata),
    .reg_rdata_i(rdata), .reg_rvalid_i(rvalid)
  );

  int fcnt [16];
  int rp [16];
  int n_rd, n_wr;
  logic [11:0] wl_off [16];
  logic [3:0]  wl_loc [16];
  logic [7:0]  wl_dat [16];
  logic [7:0]  wb [16];
  logic [7:0]  rb [16];
  bit hdr_bad, oe_bad;
  int n_chk = 0, n_err = 0;

  function automatic logic [7:0] fv(int l, int i);
    return 8'(l * 37 + i * 11 + 5);
  endfunction
  function automatic logic [7:0] rv(int l, int o);
    return 8'(l * 16 + (o & 255)) ^ 8'h5A;
  endfunction

  always @* begin
    if (off == 12'h024) begin
      rvalid = rp[loc] < fcnt[loc];
      rdata  = fv(int'(loc), rp[loc]);
    end else begin
      rvalid = 1'b1;
      rdata  = rv(int'(loc), int'(off));
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) rp[i] <= 0;
      n_rd <= 0;
      n_wr <= 0;
    end else if (stb) begin
      if (we) begin
        wl_off[n_wr % 16] <= off;
        wl_loc[n_wr % 16] <= loc;
        wl_dat[n_wr % 16] <= wdata;
        n_wr <= n_wr + 1;
      end else begin
        n_rd <= n_rd + 1;
        if (off == 12'h024 && rvalid) rp[loc] <= rp[loc] + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [23:0] addr, input int nb, input int stop_at);
    logic [31:0] hdr;
    int total;
    hdr = {cmd, addr};
    total = 32 + 8 * nb;
    hdr_bad = 1'b0;
    oe_bad = 1'b0;
    for (int k = 0; k < 16; k++) rb[k] = 8'h00;
    @(posedge clk); #1 cs_n = 1'b0;
    repeat (H) @(posedge clk);
    for (int b = 0; b < total; b++) begin
      if (b == stop_at) break;
      #1 mosi = (b < 32) ? hdr[31-b] : wb[(b-32)/8][7-((b-32)%8)];
      repeat (H) @(posedge clk);
      #1;
      if (!oe) oe_bad = 1'b1;
      if (b < 32) begin
        if (miso) hdr_bad = 1'b1;
      end else begin
        rb[(b-32)/8][7-((b-32)%8)] = miso;
      end
      sclk = 1'b1;
      repeat (H) @(posedge clk);
      #1 sclk = 1'b0;
    end
    repeat (H) @(posedge clk);
    #1 cs_n = 1'b1;
    repeat (8) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", n_chk + 1, n_err + 1);
    $finish;
  end

  initial begin
    int base, rd0, wr0;
    logic [7:0] e;
    for (int i = 0; i < 16; i++) fcnt[i] = (i < 5) ? 3 : ((i == 5) ? 2 : 0);
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 miso", int'(miso), 0);
    chk("R11 oe", int'(oe), 0);
    chk("R11 stb", int'(stb), 0);

    // R4 one-byte read: 40 SCLK cycles
    rd0 = n_rd;
    xfer(8'h80, 24'hD40024, 1, -1);
    chk("R4 data", int'(rb[0]), int'(fv(0, 0)));
    chk("R4 strobes", n_rd - rd0, 1);
    chk("R5 header miso", int'(hdr_bad), 0);
    chk("R1 oe during cs", int'(oe_bad), 0);
    chk("R1 oe after cs", int'(oe), 0);

    // R8 R9 R3 R6: FIFO sweep over localities, 5-byte cmd clocked for 6
    for (int l = 0; l < 5; l++) begin
      base = rp[l];
      rd0 = n_rd;
      xfer(8'h84, {8'hD4, 4'(l), 12'h024}, 6, -1);
      for (int i = 0; i < 5; i++) begin
        e = (base + i < fcnt[l]) ? fv(l, base + i) : 8'hFF;
        chk("R8 fifo byte", int'(rb[i]), int'(e));
      end
      chk("R9 beyond length", int'(rb[5]), 8'hFF);
      chk("R3 strobe count", n_rd - rd0, 5);
      chk("R6 pops per locality", rp[l], fcnt[l]);
    end

    // R8 non-FIFO offsets increment; R9 beyond length
    rd0 = n_rd;
    xfer(8'h82, 24'hD42010, 5, -1);
    for (int i = 0; i < 3; i++) chk("R8 incr read", int'(rb[i]), int'(rv(2, 16 + i)));
    chk("R9 extra0", int'(rb[3]), 8'hFF);
    chk("R9 extra1", int'(rb[4]), 8'hFF);
    chk("R3 strobes", n_rd - rd0, 3);

    // R2 bit 6 ignored on read
    xfer(8'hC1, 24'hD41100, 2, -1);
    chk("R2 rsvd rd0", int'(rb[0]), int'(rv(1, 12'h100)));
    chk("R2 rsvd rd1", int'(rb[1]), int'(rv(1, 12'h101)));

    // R7 undecoded read
    rd0 = n_rd;
    xfer(8'h81, 24'hD30024, 2, -1);
    chk("R7 rd0", int'(rb[0]), 8'hFF);
    chk("R7 rd1", int'(rb[1]), 8'hFF);
    chk("R7 no strobe", n_rd - rd0, 0);

    // R2 R8 R9 write to FIFO, 3-byte cmd clocked for 4
    wb[0] = 8'hA1; wb[1] = 8'hB2; wb[2] = 8'hC3; wb[3] = 8'hD4;
    wr0 = n_wr;
    rd0 = n_rd;
    xfer(8'h02, 24'hD43024, 4, -1);
    chk("R9 write count", n_wr - wr0, 3);
    chk("R2 no read on write", n_rd - rd0, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R8 fifo wr off", int'(wl_off[(wr0 + i) % 16]), 12'h024);
      chk("R6 wr loc", int'(wl_loc[(wr0 + i) % 16]), 3);
      chk("R2 wr data", int'(wl_dat[(wr0 + i) % 16]), int'(wb[i]));
    end

    // R8 incrementing write, bit 6 set
    wb[0] = 8'h11; wb[1] = 8'h22;
    wr0 = n_wr;
    xfer(8'h41, 24'hD42FFE, 2, -1);
    chk("R2 rsvd wr count", n_wr - wr0, 2);
    chk("R8 wr off0", int'(wl_off[wr0 % 16]), 12'hFFE);
    chk("R8 wr off1", int'(wl_off[(wr0 + 1) % 16]), 12'hFFF);
    chk("R6 wr loc2", int'(wl_loc[wr0 % 16]), 2);

    // R7 undecoded write
    wr0 = n_wr;
    xfer(8'h00, 24'h000024, 1, -1);
    chk("R7 no write", n_wr - wr0, 0);

    // R10 aborts
    rd0 = n_rd;
    xfer(8'h80, 24'hD45024, 1, 20);
    chk("R10 hdr abort", n_rd - rd0, 0);
    wr0 = n_wr;
    xfer(8'h00, 24'hD40024, 1, 37);
    chk("R10 byte abort", n_wr - wr0, 0);
    xfer(8'h80, 24'hD45024, 1, -1);
    chk("R10 fresh read", int'(rb[0]), int'(fv(5, 0)));
    chk("R5 header after abort", int'(hdr_bad), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule